// File: doc/BRIEF.md
# Option-Select Register File with ROM Window Decoder

This block sits behind the card-setup port of a plug-in adapter on a configurable expansion bus. It holds eight byte-wide option-select registers. The two lowest offsets return fixed adapter identification bytes. Offsets 2 to 7 are ordinary storage that the host can read and write while the card-setup strobe is raised.

Offset 2 is the configuration byte. Its bit 0 enables the adapter's 16 KB option-ROM window. Its bits 7:5 carry a sparse code that selects where the window sits in the 20-bit memory space. The block turns this byte into a registered window base and an enable. It compares every incoming memory address against that window and raises an address-hit signal when the address falls inside it. A feedback bit returns the enable state to the setup logic. The ROM contents and the adapter datapath are outside this block.

Top module: `optsel_rom_decoder`

## Requirements
- R1: A read at offset 0 returns 0x8D and a read at offset 1 returns 0x70. Writes to offsets 0 and 1 change neither the read data nor the ROM mapping.
- R2: A read at offset 2 to 7 returns the last byte accepted for that offset. The offset is taken from `reg_idx[2:0]`. Read data is combinational.
- R3: While `rst_n` is low at a clock edge, offsets 2 to 7 clear to zero, the mapping is disabled, `rom_base` becomes 0xD8000 and `setup_fb` is 0.
- R4: An accepted write that leaves offset 2 with bit 0 set selects the base from bits 7:5 of offset 2. The codes map as follows: 000 gives 0xD4000, 001 gives 0xD0000, 010 gives 0xCC000, 011 gives 0xC8000, 110 gives 0xDC000 and 111 gives 0xD8000. The new base is visible from the clock edge that accepts the write.
- R5: Codes 100 and 101 in bits 7:5 leave `rom_base` at its previous value.
- R6: An accepted write that leaves offset 2 bit 0 clear disables the mapping and leaves `rom_base` unchanged.
- R7: `rom_hit` is 1 exactly when the mapping is enabled and `rom_base <= mem_addr <= rom_base + 0x3FFF`.
- R8: `setup_fb` always equals bit 0 of offset 2.
- R9: A write is accepted only when `wr_en` and `setup_sel` are both 1 at a clock edge. Any other write attempt changes no register and no mapping.
- R10: An accepted write to offsets 3 to 7 re-evaluates the mapping from the unchanged offset 2. The enable and the base therefore stay as they were.
- R11: `rom_hit` in the cycle of an accepted write is based on the mapping from before that write. The new mapping applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_sel | input | 1 | Card-setup strobe; qualifies register writes |
| wr_en | input | 1 | Register write request |
| reg_idx | input | 3 | Register offset for read and write |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data at `reg_idx` |
| mem_addr | input | 20 | Memory address to compare against the ROM window |
| rom_hit | output | 1 | Address lies inside the enabled ROM window |
| rom_base | output | 20 | Currently decoded ROM window base |
| setup_fb | output | 1 | Card-setup feedback (the enable bit) |

## Verification
Two functions can fall in the same cycle: a memory lookup and an accepted configuration write that moves or disables the window. The bench provokes this by holding an address inside the old window while it writes offset 2 with a new code. Just before the edge it expects a hit from the old mapping. After the edge it expects a miss at the old address and a hit in the new window. Random write and lookup sequences are also applied, with addresses biased to the window edges, and each result is compared against a model of the register file and the decode.

// File: rtl/optsel_pkg.sv
// Package: shared widths and the sparse base-code lookup for the
// option-select ROM decoder. Assumes 16 KB-aligned window bases in a
// 20-bit memory space.
package optsel_pkg;

    localparam int OPT_ADDR_W  = 20;
    localparam int OPT_DATA_W  = 8;
    localparam int OPT_IDX_W   = 3;
    localparam int OPT_WIN_BITS = 14;
    localparam int OPT_CFG_IDX = 2;

    typedef struct packed {
        logic                  valid;
        logic [OPT_ADDR_W-1:0] base;
    } base_sel_t;

    // Maps a 3-bit placement code onto a window base; codes 100/101 are invalid.
    function automatic base_sel_t lookup_base(input logic [2:0] code);
        base_sel_t r;
        r.valid = 1'b1;
        case (code)
            3'b000:  r.base = 20'hD4000;
            3'b001:  r.base = 20'hD0000;
            3'b010:  r.base = 20'hCC000;
            3'b011:  r.base = 20'hC8000;
            3'b110:  r.base = 20'hDC000;
            3'b111:  r.base = 20'hD8000;
            default: begin
                r.valid = 1'b0;
                r.base  = '0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/optsel_regfile.sv
// Module: option-select register storage. Offsets below FIRST_RW return
// fixed ID bytes; the rest are writable storage. Provides the value that
// the configuration byte will hold after the current edge so the decoder
// can act on it in the same cycle. Assumes a synchronous active-low reset.
module optsel_regfile #(
    parameter int          IDX_W   = 3,
    parameter int          DATA_W  = 8,
    parameter int          CFG_IDX = 2,
    parameter logic [7:0]  ID_LO   = 8'h8D,
    parameter logic [7:0]  ID_HI   = 8'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_sel,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_accept,
    output logic [DATA_W-1:0] cfg_next,
    output logic [DATA_W-1:0] cfg_q
);

    localparam int NREG     = 1 << IDX_W;
    localparam int FIRST_RW = 2;

    logic [DATA_W-1:0] store_q [FIRST_RW:NREG-1];
    logic [DATA_W-1:0] view    [NREG];
    logic              wr_hits_rw;

    // Write qualification: strobe, request and a writable offset.
    always_comb begin
        wr_hits_rw = (int'(reg_idx) >= FIRST_RW);
        wr_accept  = setup_sel && wr_en && wr_hits_rw;
    end

    // Storage update for the writable offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = FIRST_RW; i < NREG; i++) store_q[i] <= '0;
        end else if (wr_accept) begin
            for (int i = FIRST_RW; i < NREG; i++)
                if (int'(reg_idx) == i) store_q[i] <= wr_data;
        end
    end

    // Read view: fixed ID bytes below FIRST_RW, storage above.
    for (genvar g = 0; g < NREG; g++) begin : g_view
        if (g == 0) begin : g_id_lo
            assign view[g] = DATA_W'(ID_LO);
        end else if (g == 1) begin : g_id_hi
            assign view[g] = DATA_W'(ID_HI);
        end else begin : g_store
            assign view[g] = store_q[g];
        end
    end

    // Combinational read port.
    assign rd_data = view[reg_idx];

    // Configuration byte now and after this edge.
    always_comb begin
        cfg_q    = store_q[CFG_IDX];
        cfg_next = (wr_accept && (int'(reg_idx) == CFG_IDX)) ? wr_data : store_q[CFG_IDX];
    end

    p_strobe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_accept |=> $stable(cfg_q))
        else $error("config byte changed without accepted write");

    p_id_write_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && setup_sel && int'(reg_idx) < FIRST_RW) |=> $stable(cfg_q))
        else $error("ID write disturbed config byte");

endmodule

// File: rtl/optsel_base_decode.sv
// Module: turns the configuration byte into a registered window enable and
// base. The enable is cleared on every accepted write and set again when
// the new config byte has bit 0 set; the base moves only for valid codes.
// Assumes cfg_next is the config value that holds after this edge.
module optsel_base_decode
    import optsel_pkg::*;
#(
    parameter int              ADDR_W   = 20,
    parameter int              DATA_W   = 8,
    parameter int              WIN_BITS = 14,
    parameter logic [19:0]     DEF_BASE = 20'hD8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_accept,
    input  logic [DATA_W-1:0] cfg_next,
    output logic              map_en,
    output logic [ADDR_W-1:0] map_base
);

    base_sel_t sel;

    // Code lookup from the top three bits of the incoming config byte.
    always_comb sel = lookup_base(cfg_next[DATA_W-1 -: 3]);

    // Enable and base registers, updated on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_en   <= 1'b0;
            map_base <= ADDR_W'(DEF_BASE);
        end else if (wr_accept) begin
            map_en <= cfg_next[0];
            if (cfg_next[0] && sel.valid) map_base <= ADDR_W'(sel.base);
        end
    end

    p_base_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && cfg_next[DATA_W-1 -: 2] == 2'b10) |=> $stable(map_base))
        else $error("reserved code moved base");

    p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && !cfg_next[0]) |=> (!map_en && $stable(map_base)))
        else $error("clear of enable bit did not disable");

    p_base_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (map_base == 20'hD4000) || (map_base == 20'hD0000) || (map_base == 20'hCC000) ||
        (map_base == 20'hC8000) || (map_base == 20'hDC000) || (map_base == 20'hD8000))
        else $error("illegal base");

    p_base_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        map_base[WIN_BITS-1:0] == '0)
        else $error("base not window aligned");

endmodule

// File: rtl/optsel_window_match.sv
// Module: address comparator for the aligned ROM window. Assumes the base
// is aligned to 2**WIN_BITS so only the upper address bits are compared.
module optsel_window_match #(
    parameter int ADDR_W   = 20,
    parameter int WIN_BITS = 14
) (
    input  logic              map_en,
    input  logic [ADDR_W-1:0] map_base,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              hit
);

    // Upper-bit compare qualified by the enable.
    always_comb hit = map_en && (mem_addr[ADDR_W-1:WIN_BITS] == map_base[ADDR_W-1:WIN_BITS]);

endmodule

// File: rtl/optsel_rom_decoder.sv
// Module: top of the option-select register file and ROM window decoder.
// Host writes are accepted under the card-setup strobe; the window mapping
// is registered, so lookups see the mapping from before a same-cycle write.
// Assumes a synchronous active-low reset.
module optsel_rom_decoder
    import optsel_pkg::*;
#(
    parameter int          ADDR_W   = OPT_ADDR_W,
    parameter int          DATA_W   = OPT_DATA_W,
    parameter int          IDX_W    = OPT_IDX_W,
    parameter int          WIN_BITS = OPT_WIN_BITS,
    parameter logic [7:0]  ID_LO    = 8'h8D,
    parameter logic [7:0]  ID_HI    = 8'h70,
    parameter logic [19:0] DEF_BASE = 20'hD8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_sel,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              rom_hit,
    output logic [ADDR_W-1:0] rom_base,
    output logic              setup_fb
);

    logic              wr_accept;
    logic [DATA_W-1:0] cfg_next;
    logic [DATA_W-1:0] cfg_q;
    logic              map_en;

    optsel_regfile #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .CFG_IDX(OPT_CFG_IDX),
        .ID_LO(ID_LO), .ID_HI(ID_HI)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .setup_sel(setup_sel), .wr_en(wr_en),
        .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data),
        .wr_accept(wr_accept), .cfg_next(cfg_next), .cfg_q(cfg_q)
    );

    optsel_base_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .DEF_BASE(DEF_BASE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .cfg_next(cfg_next),
        .map_en(map_en), .map_base(rom_base)
    );

    optsel_window_match #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_match (
        .map_en(map_en), .map_base(rom_base), .mem_addr(mem_addr), .hit(rom_hit)
    );

    // Feedback to the setup logic is the stored enable bit.
    assign setup_fb = cfg_q[0];

    p_fb_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        setup_fb == map_en)
        else $error("feedback disagrees with mapping enable");

    p_hit_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_hit |-> setup_fb)
        else $error("hit while disabled");

    p_reset_state_r3: assert property (@(posedge clk)
        !rst_n |=> (!setup_fb && rom_base == ADDR_W'(DEF_BASE)))
        else $error("reset state wrong");

endmodule

// File: tb/test_optsel_rom_decoder.sv
module test_optsel_rom_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [19:0] mem_addr = '0;
    logic        rom_hit;
    logic [19:0] rom_base;
    logic        setup_fb;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0]  m_regs [8];
    logic        m_en;
    logic [19:0] m_base;

    always #4 clk = ~clk;

    optsel_rom_decoder i_optsel_rom_decoder (
        .clk(clk), .rst_n(rst_n), .setup_sel(setup_sel), .wr_en(wr_en),
        .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data),
        .mem_addr(mem_addr), .rom_hit(rom_hit), .rom_base(rom_base), .setup_fb(setup_fb)
    );

    function automatic logic [19:0] exp_base(input logic [2:0] code, input logic [19:0] old);
        case (code)
            3'b000: return 20'hD4000;
            3'b001: return 20'hD0000;
            3'b010: return 20'hCC000;
            3'b011: return 20'hC8000;
            3'b110: return 20'hDC000;
            3'b111: return 20'hD8000;
            default: return old;
        endcase
    endfunction

    function automatic logic exp_hit(input logic [19:0] a);
        return m_en && (a >= m_base) && (a <= m_base + 20'h3FFF);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_regs[i] = 8'h00;
        m_regs[0] = 8'h8D;
        m_regs[1] = 8'h70;
        m_en = 1'b0;
        m_base = 20'hD8000;
    endtask

    task automatic model_write(input logic [2:0] idx, input logic [7:0] d);
        if (idx >= 3'd2) begin
            m_regs[idx] = d;
            m_en = m_regs[2][0];
            if (m_en) m_base = exp_base(m_regs[2][7:5], m_base);
        end
    endtask

    task automatic do_write(input logic [2:0] idx, input logic [7:0] d,
                            input logic strobe, input logic req);
        @(negedge clk);
        setup_sel = strobe; wr_en = req; reg_idx = idx; wr_data = d;
        @(posedge clk);
        if (strobe && req) model_write(idx, d);
        @(negedge clk);
        setup_sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic chk_read(input string req, input logic [2:0] idx);
        reg_idx = idx;
        #1;
        chk(req, {24'h0, rd_data}, {24'h0, m_regs[idx]});
    endtask

    task automatic chk_addr(input string req, input logic [19:0] a);
        mem_addr = a;
        #1;
        chk(req, {31'h0, rom_hit}, {31'h0, exp_hit(a)});
    endtask

    task automatic chk_state(input string req);
        chk(req, {12'h0, rom_base}, {12'h0, m_base});
        chk({req, "/R8"}, {31'h0, setup_fb}, {31'h0, m_regs[2][0]});
    endtask

    task automatic chk_edges(input string req);
        chk_addr(req, m_base);
        chk_addr(req, m_base + 20'h3FFF);
        chk_addr(req, m_base - 20'h1);
        chk_addr(req, m_base + 20'h4000);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] code_byte;
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R3: reset state
        for (int i = 0; i < 8; i++) chk_read("R3 reset read", 3'(i));
        chk_state("R3 reset");
        chk_addr("R3 reset hit", 20'hD8000);
        rst_n = 1'b1;

        // R1: ID bytes and ignored writes
        do_write(3'd0, 8'hFF, 1'b1, 1'b1);
        do_write(3'd1, 8'h00, 1'b1, 1'b1);
        chk_read("R1 id0", 3'd0);
        chk_read("R1 id1", 3'd1);
        chk_state("R1 no map change");
        chk_addr("R1 no hit", 20'hD8000);

        // R4: each valid code
        for (int c = 0; c < 8; c++) begin
            if (c == 4 || c == 5) continue;
            code_byte = {3'(c), 5'b00001};
            do_write(3'd2, code_byte, 1'b1, 1'b1);
            chk_state("R4 base");
            chk_edges("R4/R7 window");
        end

        // R5: reserved codes keep base
        do_write(3'd2, 8'h41, 1'b1, 1'b1);
        do_write(3'd2, 8'h81, 1'b1, 1'b1);
        chk_state("R5 code100");
        do_write(3'd2, 8'hA1, 1'b1, 1'b1);
        chk_state("R5 code101");
        chk_edges("R5 window");

        // R6: clear enable bit with a different code
        do_write(3'd2, 8'h60, 1'b1, 1'b1);
        chk_state("R6 disable");
        chk_edges("R6 no hit");

        // R9: write without strobe, and strobe without write
        do_write(3'd2, 8'h21, 1'b0, 1'b1);
        chk_read("R9 ignored", 3'd2);
        chk_state("R9 ignored");
        do_write(3'd4, 8'h55, 1'b1, 1'b0);
        chk_read("R9 no req", 3'd4);

        // R10: write to other offsets keeps mapping
        do_write(3'd2, 8'h21, 1'b1, 1'b1);
        do_write(3'd5, 8'hAA, 1'b1, 1'b1);
        chk_read("R10/R2 read", 3'd5);
        chk_state("R10 map kept");
        chk_edges("R10 window");

        // R11: lookup in the same cycle as a moving write
        do_write(3'd2, 8'h01, 1'b1, 1'b1);
        @(negedge clk);
        mem_addr = 20'hD4010;
        setup_sel = 1'b1; wr_en = 1'b1; reg_idx = 3'd2; wr_data = 8'h21;
        #1;
        chk("R11 old map", {31'h0, rom_hit}, 32'h1);
        @(posedge clk);
        model_write(3'd2, 8'h21);
        @(negedge clk);
        setup_sel = 1'b0; wr_en = 1'b0;
        #1;
        chk("R11 new map miss", {31'h0, rom_hit}, 32'h0);
        chk_addr("R11 new map hit", 20'hD0010);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  ri;
            logic [7:0]  rd;
            logic [19:0] ra;
            ri = 3'($urandom % 8);
            if ($urandom % 3 == 0) ri = 3'd2;
            rd = 8'($urandom);
            do_write(ri, rd, ($urandom % 10) != 0, ($urandom % 8) != 0);
            chk_read("R2 random read", 3'($urandom % 8));
            chk_state("R4 random state");
            case ($urandom % 3)
                0: ra = m_base + 20'($urandom % 32'h4000);
                1: ra = ($urandom % 2) ? m_base - 20'h1 : m_base + 20'h4000;
                default: ra = 20'($urandom);
            endcase
            chk_addr("R7 random hit", ra);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule